// File: doc/BRIEF.md
# Selectable Power-of-Two Clock Divider

This block takes a fast input clock, in practice the oscillator clock of a frequency synthesizer modelled here as an ordinary digital clock, and hands out a slower copy of it divided by 1, 2, 4 or 8. A 2-bit code picks the ratio. The result leaves as a true/complement pair, and both halves of each output period are equal in every setting, divide-by-1 included. An output-enable input parks the pair in a fixed state: true output low, complement high. For a source clock between 250 and 700 MHz, the four ratios give outputs from 31.25 MHz up to 700 MHz.

A free-running counter makes the divided phases. The code and the enable are taken in only on the falling input-clock edge of the cycle in which the counter is zero. At that point every candidate phase is low. A ratio change or an enable change therefore never cuts a pulse short and never adds a sliver of one. The complement output comes from its own selection path and is the exact inverse of the true output at every instant.

Top module: `pow2_clk_divider`

## Requirements
- R1: While reset is asserted, the true output is 0 and the complement output is 1. The phase counter is cleared. The active ratio defaults to code 11 (divide by 8) and the enable defaults to active.
- R2: With active code 00, the true output equals the input clock: high while the clock is high and low while it is low.
- R3: With active code 01, 10 or 11 (ratio N = 2, 4 or 8), the true output is high exactly when the number of rising edges since reset release, taken modulo N, is at least N/2. This gives a 50% duty square wave of period N input cycles.
- R4: A change of the code or the enable input becomes active only at a falling input-clock edge that occurs while the rising-edge count modulo 8 is 0. At every other edge, input changes have no effect on the outputs.
- R5: When the active enable is 0, the true output is held at 0 and the complement output at 1, whatever the code and the clock.
- R6: The complement output is always the logical inverse of the true output.
- R7: On reset release the phase counter restarts at zero. The first rising edge after release counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_code_i | input | 2 | Ratio code: 00 = /1, 01 = /2, 10 = /4, 11 = /8 |
| out_en_i | input | 1 | Output enable, 1 = running, 0 = parked |
| clk_o | output | 1 | Divided clock, true polarity |
| clk_no | output | 1 | Divided clock, complement polarity |

## Verification
The code capture and the enable capture share the same falling edge, so a new ratio and a disable, or a re-enable, can take effect in the same cycle. The bench provokes this by moving both inputs together inside one count window and also by moving them in the middle of a window. A behavioural model counts rising edges and latches its own copy of both inputs at the count-zero falling edge. Both outputs are compared against this model in the high and the low half of every clock cycle, so an early capture, a late capture or a partial pulse shows up as a miscompare.

// File: rtl/odiv_pkg.sv
package odiv_pkg;
    // width of the ratio select code
    localparam int CODE_W   = 2;
    // number of selectable phases (input clock plus divided ones)
    localparam int N_PHASE  = 1 << CODE_W;
    // counter bits needed for the slowest ratio
    localparam int CNT_W    = N_PHASE - 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // configuration that is actually in force
    typedef struct packed {
        code_t code;
        logic  en;
    } cfg_t;

    // after reset: slowest ratio, outputs running
    localparam cfg_t CFG_RESET = '{code: {CODE_W{1'b1}}, en: 1'b1};
endpackage

// File: rtl/odiv_phase_ctr.sv
module odiv_phase_ctr
    import odiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    output cnt_t cnt_o
);
    typedef struct packed {
        cnt_t cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + cnt_t'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/odiv_cfg_capture.sv
module odiv_cfg_capture
    import odiv_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  cnt_t  cnt_i,
    input  code_t code_i,
    input  logic  en_i,
    output cfg_t  cfg_o
);
    typedef struct packed {
        cfg_t cfg;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       window_open;

    // all divided phases are low during the count-zero cycle, and the
    // input clock has just fallen at the falling edge inside it
    assign window_open = (cnt_i == '0);

    always_comb begin
        st_d = st_q;
        if (window_open) begin
            st_d.cfg.code = code_i;
            st_d.cfg.en   = en_i;
        end
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cfg <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;
endmodule

// File: rtl/odiv_out_sel.sv
module odiv_out_sel
    import odiv_pkg::*;
(
    input  logic clk_i,
    input  cnt_t cnt_i,
    input  cfg_t cfg_i,
    output logic true_o,
    output logic comp_o
);
    logic [N_PHASE-1:0] phase_p;
    logic [N_PHASE-1:0] phase_n;

    // phase 0 is the input clock itself, phase k is counter bit k-1
    generate
        for (genvar k = 0; k < N_PHASE; k++) begin : g_phase
            if (k == 0) begin : g_direct
                assign phase_p[k] = clk_i;
                assign phase_n[k] = ~clk_i;
            end else begin : g_counted
                assign phase_p[k] = cnt_i[k-1];
                assign phase_n[k] = ~cnt_i[k-1];
            end
        end
    endgenerate

    // separate select paths so neither output is a delayed copy of the other
    always_comb begin
        true_o = 1'b0;
        comp_o = 1'b1;
        if (cfg_i.en) begin
            true_o = phase_p[cfg_i.code];
            comp_o = phase_n[cfg_i.code];
        end
    end
endmodule

// File: rtl/pow2_clk_divider.sv
module pow2_clk_divider
    import odiv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] div_code_i,
    input  logic              out_en_i,
    output logic              clk_o,
    output logic              clk_no
);
    cnt_t cnt_w;
    cfg_t cfg_w;

    odiv_phase_ctr u_ctr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_o  (cnt_w)
    );

    odiv_cfg_capture u_cap (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_i  (cnt_w),
        .code_i (div_code_i),
        .en_i   (out_en_i),
        .cfg_o  (cfg_w)
    );

    odiv_out_sel u_sel (
        .clk_i  (clk_i),
        .cnt_i  (cnt_w),
        .cfg_i  (cfg_w),
        .true_o (clk_o),
        .comp_o (clk_no)
    );
endmodule

// File: rtl/pow2_clk_divider_chk.sv
module pow2_clk_divider_chk
    import odiv_pkg::*;
(
    input logic  clk_i,
    input logic  rst_ni,
    input cnt_t  cnt,
    input cfg_t  cfg,
    input logic  out_p,
    input logic  out_n
);
    // R1: counter held clear while reset is low
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            assert_cnt_clear_R1: assert (cnt == '0)
                else $error("counter not clear in reset");
        end
    end

    // R4: configuration may only move in a count-zero cycle
    assert_cfg_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt != '0) |-> $stable(cfg));

    // R5: parked levels while disabled
    assert_parked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg.en) |-> (out_p == 1'b0 && out_n == 1'b1));

    // R6: complement is the inverse of the true output
    assert_comp_inverse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_n == !out_p);

    // R3: divide-by-2 alternates on every rising edge once settled
    assert_half_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg.en && $past(cfg.en) && cfg.code == code_t'(1) && $past(cfg.code) == code_t'(1))
        |-> (out_p != $past(out_p)));
endmodule

bind pow2_clk_divider pow2_clk_divider_chk u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt    (cnt_w),
    .cfg    (cfg_w),
    .out_p  (clk_o),
    .out_n  (clk_no)
);

// File: tb/tb_pow2_clk_divider.sv
`timescale 1ns/1ps
module tb_pow2_clk_divider;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [1:0] div_code_i = 2'b00;
    logic       out_en_i = 1'b1;
    logic       clk_o, clk_no;

    pow2_clk_divider dut (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .div_code_i (div_code_i),
        .out_en_i   (out_en_i),
        .clk_o      (clk_o),
        .clk_no     (clk_no)
    );

    always #10 clk_i = ~clk_i;   // 50 MHz

    int    n_vec  = 0;
    int    n_bad  = 0;
    bit    done   = 1'b0;
    int    m_edges;      // rising edges since reset release
    int    m_code;       // model's active code
    bit    m_en;         // model's active enable
    string req = "R1";

    function automatic bit model_true(input bit hi);
        int n;
        if (!m_en) return 1'b0;
        if (m_code == 0) return hi;
        n = 1 << m_code;
        return ((m_edges % n) >= n / 2);
    endfunction

    task automatic compare(input bit hi);
        bit e = model_true(hi);
        n_vec++;
        if (clk_o !== e) begin
            n_bad++;
            $display("FAIL %s clk_o t=%0t got %b exp %b (code %0d en %0b edges %0d)",
                     req, $time, clk_o, e, m_code, m_en, m_edges);
        end
        n_vec++;
        if (clk_no !== ~e) begin
            n_bad++;
            $display("FAIL R6 clk_no t=%0t got %b exp %b", $time, clk_no, ~e);
        end
    endtask

    task automatic model_reset();
        m_edges = 0;
        m_code  = 3;
        m_en    = 1'b1;
    endtask

    // one input clock cycle: compare in the high half and the low half
    task automatic cycle();
        @(posedge clk_i);
        if (rst_ni) m_edges++;
        #5 compare(1'b1);
        @(negedge clk_i);
        if (rst_ni && (m_edges % 8 == 0)) begin
            m_code = div_code_i;
            m_en   = out_en_i;
        end
        #5 compare(1'b0);
    endtask

    task automatic run(input int cyc);
        for (int i = 0; i < cyc; i++) cycle();
    endtask

    initial begin
        model_reset();
        // R1: reset state, inputs disagreeing with the defaults
        req = "R1";
        div_code_i = 2'b00;
        out_en_i   = 1'b0;
        run(4);
        // R7: release in the low half; counting starts from zero
        rst_ni = 1'b1;
        req = "R7";
        run(8);     // still default /8 in the first window; capture at count 0 edge
        // R2: the /1 code with enable 0 was captured, now running parked (R5)
        req = "R5";
        run(8);
        out_en_i = 1'b1;
        req = "R2";
        run(24);
        // R3: each divided ratio
        div_code_i = 2'b01; req = "R3"; run(24);
        div_code_i = 2'b10; req = "R3"; run(32);
        div_code_i = 2'b11; req = "R3"; run(40);
        // R4: change the code in the middle of a window; no effect until count 0
        run(3);
        div_code_i = 2'b01; req = "R4";
        run(2);
        div_code_i = 2'b10;
        run(1);
        div_code_i = 2'b00;
        run(20);
        // R4/R5: code and enable move together in one window
        run(5);
        div_code_i = 2'b11; out_en_i = 1'b0; req = "R4";
        run(16);
        div_code_i = 2'b01; out_en_i = 1'b1;
        run(16);
        // R5: glitchy enable pulse between capture edges is ignored
        run(2);
        out_en_i = 1'b0; run(2); out_en_i = 1'b1; req = "R5";
        run(12);
        // R7: reset in the middle of a /4 run, counter restarts at zero
        div_code_i = 2'b10; run(16);
        run(3);
        rst_ni = 1'b0; model_reset(); req = "R1";
        run(3);
        rst_ni = 1'b1; req = "R7";
        run(24);
        // R2: back to /1, then /2, to check phase after the restart
        div_code_i = 2'b00; req = "R2"; run(16);
        div_code_i = 2'b01; req = "R3"; run(16);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired at t=%0t", $time);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule